// File: doc/BRIEF.md
# Speculative Load-Store Ordering Queue

This block keeps track of every load and store that is in flight in one core. Each operation takes a slot in its own queue, loads in one and stores in the other, in program order. When the address generators report a resolved physical address, the slot is updated with it. For each resolved load, the block then decides whether it may be sent to the memory pipeline ahead of older stores. A load may always pass an older store whose address is known to lie in a different 8-byte block. It may pass an older store whose address is still unknown only when a small dependence predictor, indexed by the load's instruction address, marks that load as safe.

Each cycle the block grants the oldest load that is allowed to issue. It watches store address resolutions for loads that went early and turned out to overlap. When this happens, it raises a one-cycle violation flag with the offending load's slot, and it trains that load's predictor entry so the load waits next time. A load-op-store pair can be allocated as one fused operation. The load's address resolution then also fills in the paired store, so the store never needs an address-generation slot of its own.

Top module: `lsq_order_top`

## Requirements
- R1: Each queue accepts an allocation only while it holds fewer entries than its depth (40 loads, 24 stores by default), and its ready output is low when it is full. A request made while the queue is full is dropped and the queue's tail index stays as it was. The two queues fill independently. A fused allocation is taken only when both queues have room.
- R2: Slots are handed out in age order. The tail index shown on `ld_alloc_idx` / `st_alloc_idx` wraps to 0 after depth-1. The oldest load is freed by `ld_complete` once it has been granted, and the oldest store is freed by `st_retire` once its address is resolved.
- R3: A resolved load whose older stores all have resolved addresses in a different 8-byte block (physical address bits [47:3] differ) is granted.
- R4: A load that has an older, resolved store in the same 8-byte block is not granted until that store retires.
- R5: The predictor has one 2-bit counter per entry (64 by default), indexed by the low bits of the load's instruction address. All counters reset to 0. A counter value below 2 means the load may pass older stores with unknown addresses; a value of 2 or 3 makes it wait for them.
- R6: A store address that resolves into the same 8-byte block as a younger load that is already granted, or is granted in that same cycle, raises `viol_valid` for one cycle, in the next cycle, with that load's slot. If several loads match, the oldest one is reported.
- R7: A violation sets the predictor counter of the offending load's instruction address to 3. Later loads from that address then wait for older unresolved stores.
- R8: For a fused load-op-store allocation, the load's address resolution also resolves the paired store with the same address. No store-address input is used for it.
- R9: At most one load is granted per cycle. The grant goes to the oldest eligible load, and each load is granted once.
- R10: After reset both queues are empty, both ready outputs are high, both tail indices are 0, and no grant or violation is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_alloc_valid | input | 1 | Allocate a load slot |
| ld_alloc_pcidx | input | $clog2(PRED_ENTRIES) | Low instruction-address bits of the load |
| ld_alloc_ready | output | 1 | Load queue has room |
| ld_alloc_idx | output | $clog2(LQ_DEPTH) | Slot the next load receives |
| st_alloc_valid | input | 1 | Allocate a store slot |
| st_alloc_ready | output | 1 | Store queue has room |
| st_alloc_idx | output | $clog2(SQ_DEPTH) | Slot the next store receives |
| alloc_fused | input | 1 | The load and store allocated together form one load-op-store pair |
| ld_addr_valid | input | 1 | A load address is resolved |
| ld_addr_idx | input | $clog2(LQ_DEPTH) | Load slot being resolved |
| ld_addr_blk | input | 45 | Physical address bits [47:3] of the load |
| st_addr_valid | input | 1 | A store address is resolved |
| st_addr_idx | input | $clog2(SQ_DEPTH) | Store slot being resolved |
| st_addr_blk | input | 45 | Physical address bits [47:3] of the store |
| ld_complete | input | 1 | Free the oldest load |
| st_retire | input | 1 | Free the oldest store |
| ld_issue_valid | output | 1 | A load is granted this cycle |
| ld_issue_idx | output | $clog2(LQ_DEPTH) | Slot of the granted load |
| viol_valid | output | 1 | An ordering violation was found |
| viol_idx | output | $clog2(LQ_DEPTH) | Slot of the load that violated |

## Verification
The bench builds the block with a 4-entry load queue, a 3-entry store queue and an 8-entry predictor. With these sizes both queues fill and wrap within a few operations, so full-queue stalls, index wraparound and slot reuse after frees are all reached quickly. The bench runs a speculative pass that ends in a violation, the trained wait that follows it, a same-block store that holds a load until it retires, and a fused pair whose load address releases a younger waiting load. Two grants that become eligible in the same cycle show the oldest-first order.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int PA_W    = 48;
    localparam int BLK_LSB = 3;

    // 8-byte block number of a physical address
    typedef logic [PA_W-1:BLK_LSB] blk_t;

    typedef struct packed {
        logic valid;
        logic resolved;
        logic issued;
        logic safe;
        blk_t blk;
    } ld_ent_t;

    typedef struct packed {
        logic valid;
        logic resolved;
        logic fused;
        blk_t blk;
    } st_ent_t;

    localparam logic [1:0] CTR_WAIT = 2'd3;

    function automatic logic ctr_is_safe(input logic [1:0] ctr);
        return !ctr[1];
    endfunction

endpackage

// File: rtl/lsq_pred.sv
module lsq_pred
    import lsq_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_safe,
    input  logic          trn_valid,
    input  logic [IW-1:0] trn_idx
);

    logic [1:0] ctr [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ctr[i] <= 2'd0;
        end else if (trn_valid) begin
            ctr[trn_idx] <= CTR_WAIT;
        end
    end

    assign rd_safe = ctr_is_safe(ctr[rd_idx]);

    AST_PRED_TRAINED: assert property (@(posedge clk) disable iff (rst)
        trn_valid |=> (ctr[$past(trn_idx)] == CTR_WAIT)); // R7

endmodule

// File: rtl/lsq_store_q.sv
module lsq_store_q
    import lsq_pkg::*;
#(
    parameter int SQ_DEPTH = 24,
    parameter int LQ_DEPTH = 40,
    localparam int SIW = $clog2(SQ_DEPTH),
    localparam int LIW = $clog2(LQ_DEPTH),
    localparam int CW  = $clog2(SQ_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_fire,
    input  logic                alloc_fused,
    input  logic [LIW-1:0]      alloc_link,
    input  logic                addr_valid,
    input  logic [SIW-1:0]      addr_idx,
    input  blk_t                addr_blk,
    input  logic                ld_res_valid,
    input  logic [LIW-1:0]      ld_res_idx,
    input  blk_t                ld_res_blk,
    input  logic                retire_req,
    output logic                full,
    output logic [SIW-1:0]      tail,
    output logic [SQ_DEPTH-1:0] st_valid,
    output logic [SQ_DEPTH-1:0] st_res,
    output blk_t                st_blk [SQ_DEPTH],
    output logic                free_valid,
    output logic [SIW-1:0]      free_idx,
    output logic                evt_a_valid,
    output logic [SIW-1:0]      evt_a_idx,
    output blk_t                evt_a_blk,
    output logic                evt_b_valid,
    output logic [SIW-1:0]      evt_b_idx,
    output blk_t                evt_b_blk
);

    st_ent_t        ent  [SQ_DEPTH];
    logic [LIW-1:0] link [SQ_DEPTH];
    logic [SIW-1:0] head;
    logic [CW-1:0]  count;

    function automatic logic [SIW-1:0] wrap_inc(input logic [SIW-1:0] p);
        return (p == SIW'(SQ_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full       = (count == CW'(SQ_DEPTH));
    assign free_valid = retire_req && ent[head].valid && ent[head].resolved;
    assign free_idx   = head;

    // direct resolution from an address generator
    assign evt_a_valid = addr_valid && ent[addr_idx].valid && !ent[addr_idx].resolved
                         && !ent[addr_idx].fused;
    assign evt_a_idx   = addr_idx;
    assign evt_a_blk   = addr_blk;

    // resolution borrowed from the paired load
    always_comb begin
        evt_b_valid = 1'b0;
        evt_b_idx   = '0;
        for (int j = 0; j < SQ_DEPTH; j++) begin
            if (ld_res_valid && ent[j].valid && ent[j].fused && !ent[j].resolved
                && link[j] == ld_res_idx) begin
                evt_b_valid = 1'b1;
                evt_b_idx   = SIW'(j);
            end
        end
    end
    assign evt_b_blk = ld_res_blk;

    always_comb begin
        for (int j = 0; j < SQ_DEPTH; j++) begin
            st_valid[j] = ent[j].valid;
            st_res[j]   = ent[j].resolved;
            st_blk[j]   = ent[j].blk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < SQ_DEPTH; j++) begin
                ent[j]  <= '0;
                link[j] <= '0;
            end
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc_fire) begin
                ent[tail]  <= '{valid: 1'b1, resolved: 1'b0, fused: alloc_fused, blk: '0};
                link[tail] <= alloc_link;
                tail       <= wrap_inc(tail);
            end
            if (evt_a_valid) begin
                ent[evt_a_idx].resolved <= 1'b1;
                ent[evt_a_idx].blk      <= evt_a_blk;
            end
            if (evt_b_valid) begin
                ent[evt_b_idx].resolved <= 1'b1;
                ent[evt_b_idx].blk      <= evt_b_blk;
            end
            if (free_valid) begin
                ent[head] <= '0;
                head      <= wrap_inc(head);
            end
            count <= count + CW'(alloc_fire) - CW'(free_valid);
        end
    end

    AST_SQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(SQ_DEPTH)); // R1

    AST_SQ_FUSED_FILL: assert property (@(posedge clk) disable iff (rst)
        evt_b_valid |=> st_res[$past(evt_b_idx)]); // R8

endmodule

// File: rtl/lsq_load_q.sv
module lsq_load_q
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH = 40,
    parameter int SQ_DEPTH = 24,
    parameter int PI_W     = 6,
    localparam int LIW = $clog2(LQ_DEPTH),
    localparam int SIW = $clog2(SQ_DEPTH),
    localparam int CW  = $clog2(LQ_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_fire,
    input  logic [PI_W-1:0]     alloc_pidx,
    input  logic                alloc_safe,
    input  logic [SQ_DEPTH-1:0] st_valid,
    input  logic [SQ_DEPTH-1:0] st_res,
    input  blk_t                st_blk [SQ_DEPTH],
    input  logic                st_free_valid,
    input  logic [SIW-1:0]      st_free_idx,
    input  logic                addr_valid,
    input  logic [LIW-1:0]      addr_idx,
    input  blk_t                addr_blk,
    input  logic                evt_a_valid,
    input  logic [SIW-1:0]      evt_a_idx,
    input  blk_t                evt_a_blk,
    input  logic                evt_b_valid,
    input  logic [SIW-1:0]      evt_b_idx,
    input  blk_t                evt_b_blk,
    input  logic                complete_req,
    output logic                full,
    output logic [LIW-1:0]      tail,
    output logic                issue_valid,
    output logic [LIW-1:0]      issue_idx,
    output logic                viol_valid,
    output logic [LIW-1:0]      viol_idx,
    output logic                trn_valid,
    output logic [PI_W-1:0]     trn_pidx
);

    ld_ent_t             ent   [LQ_DEPTH];
    logic [SQ_DEPTH-1:0] older [LQ_DEPTH];
    logic [PI_W-1:0]     pidx  [LQ_DEPTH];
    logic [LIW-1:0]      head;
    logic [CW-1:0]       count;

    logic [LQ_DEPTH-1:0] elig, hit;
    logic                grant_v, hit_v;
    logic [LIW-1:0]      grant_idx, hit_idx;
    logic                cpl_fire;

    function automatic logic [LIW-1:0] wrap_inc(input logic [LIW-1:0] p);
        return (p == LIW'(LQ_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CW'(LQ_DEPTH));
    assign cpl_fire = complete_req && ent[head].valid && ent[head].issued;

    // eligibility against every older store
    always_comb begin
        for (int i = 0; i < LQ_DEPTH; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < SQ_DEPTH; j++) begin
                if (older[i][j] && st_valid[j]) begin
                    if (st_res[j]) begin
                        if (st_blk[j] == ent[i].blk) blocked = 1'b1;
                    end else if (!ent[i].safe) begin
                        blocked = 1'b1;
                    end
                end
            end
            elig[i] = ent[i].valid && ent[i].resolved && !ent[i].issued && !blocked;
        end
    end

    // oldest eligible load, scanning from head
    always_comb begin
        grant_v   = 1'b0;
        grant_idx = '0;
        for (int k = 0; k < LQ_DEPTH; k++) begin
            int t;
            t = int'(head) + k;
            if (t >= LQ_DEPTH) t = t - LQ_DEPTH;
            if (!grant_v && elig[t]) begin
                grant_v   = 1'b1;
                grant_idx = LIW'(t);
            end
        end
    end

    // issued (or issuing) loads overlapped by a store resolving now
    always_comb begin
        for (int i = 0; i < LQ_DEPTH; i++) begin
            logic went;
            went   = ent[i].issued || (grant_v && grant_idx == LIW'(i));
            hit[i] = ent[i].valid && went &&
                     ((evt_a_valid && older[i][evt_a_idx] && evt_a_blk == ent[i].blk) ||
                      (evt_b_valid && older[i][evt_b_idx] && evt_b_blk == ent[i].blk));
        end
        hit_v   = 1'b0;
        hit_idx = '0;
        for (int k = 0; k < LQ_DEPTH; k++) begin
            int t;
            t = int'(head) + k;
            if (t >= LQ_DEPTH) t = t - LQ_DEPTH;
            if (!hit_v && hit[t]) begin
                hit_v   = 1'b1;
                hit_idx = LIW'(t);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LQ_DEPTH; i++) begin
                ent[i]   <= '0;
                older[i] <= '0;
                pidx[i]  <= '0;
            end
            head        <= '0;
            tail        <= '0;
            count       <= '0;
            issue_valid <= 1'b0;
            issue_idx   <= '0;
            viol_valid  <= 1'b0;
            viol_idx    <= '0;
            trn_valid   <= 1'b0;
            trn_pidx    <= '0;
        end else begin
            if (alloc_fire) begin
                ent[tail]   <= '{valid: 1'b1, resolved: 1'b0, issued: 1'b0,
                                 safe: alloc_safe, blk: '0};
                older[tail] <= st_valid;
                pidx[tail]  <= alloc_pidx;
                tail        <= wrap_inc(tail);
            end
            if (st_free_valid) begin
                for (int i = 0; i < LQ_DEPTH; i++) older[i][st_free_idx] <= 1'b0;
            end
            if (addr_valid && ent[addr_idx].valid && !ent[addr_idx].resolved) begin
                ent[addr_idx].resolved <= 1'b1;
                ent[addr_idx].blk      <= addr_blk;
            end
            if (grant_v) ent[grant_idx].issued <= 1'b1;
            if (cpl_fire) begin
                ent[head] <= '0;
                head      <= wrap_inc(head);
            end
            count       <= count + CW'(alloc_fire) - CW'(cpl_fire);
            issue_valid <= grant_v;
            issue_idx   <= grant_idx;
            viol_valid  <= hit_v;
            viol_idx    <= hit_idx;
            trn_valid   <= hit_v;
            trn_pidx    <= pidx[hit_idx];
        end
    end

    AST_LQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(LQ_DEPTH)); // R1

    AST_GRANT_RESOLVED: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (ent[issue_idx].valid && ent[issue_idx].resolved)); // R9

    AST_VIOL_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> (ent[viol_idx].valid && ent[viol_idx].issued)); // R6

endmodule

// File: rtl/lsq_order_top.sv
module lsq_order_top
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH     = 40,
    parameter int SQ_DEPTH     = 24,
    parameter int PRED_ENTRIES = 64,
    localparam int LIW  = $clog2(LQ_DEPTH),
    localparam int SIW  = $clog2(SQ_DEPTH),
    localparam int PI_W = $clog2(PRED_ENTRIES),
    localparam int BW   = PA_W - BLK_LSB
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_alloc_valid,
    input  logic [PI_W-1:0] ld_alloc_pcidx,
    output logic            ld_alloc_ready,
    output logic [LIW-1:0]  ld_alloc_idx,
    input  logic            st_alloc_valid,
    output logic            st_alloc_ready,
    output logic [SIW-1:0]  st_alloc_idx,
    input  logic            alloc_fused,
    input  logic            ld_addr_valid,
    input  logic [LIW-1:0]  ld_addr_idx,
    input  logic [BW-1:0]   ld_addr_blk,
    input  logic            st_addr_valid,
    input  logic [SIW-1:0]  st_addr_idx,
    input  logic [BW-1:0]   st_addr_blk,
    input  logic            ld_complete,
    input  logic            st_retire,
    output logic            ld_issue_valid,
    output logic [LIW-1:0]  ld_issue_idx,
    output logic            viol_valid,
    output logic [LIW-1:0]  viol_idx
);

    logic lq_full, sq_full, fused_req, ld_fire, st_fire, pred_safe;
    logic trn_valid;
    logic [PI_W-1:0] trn_pidx;

    logic [SQ_DEPTH-1:0] st_valid, st_res;
    blk_t                st_blk [SQ_DEPTH];
    logic                st_free_valid;
    logic [SIW-1:0]      st_free_idx;
    logic                evt_a_valid, evt_b_valid;
    logic [SIW-1:0]      evt_a_idx, evt_b_idx;
    blk_t                evt_a_blk, evt_b_blk;

    assign ld_alloc_ready = !lq_full;
    assign st_alloc_ready = !sq_full;
    assign fused_req = alloc_fused && ld_alloc_valid && st_alloc_valid;
    assign ld_fire   = fused_req ? (!lq_full && !sq_full) : (ld_alloc_valid && !lq_full);
    assign st_fire   = fused_req ? (!lq_full && !sq_full) : (st_alloc_valid && !sq_full);

    lsq_pred #(.ENTRIES(PRED_ENTRIES)) u_pred (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (ld_alloc_pcidx),
        .rd_safe   (pred_safe),
        .trn_valid (trn_valid),
        .trn_idx   (trn_pidx)
    );

    lsq_store_q #(.SQ_DEPTH(SQ_DEPTH), .LQ_DEPTH(LQ_DEPTH)) u_sq (
        .clk          (clk),
        .rst          (rst),
        .alloc_fire   (st_fire),
        .alloc_fused  (fused_req),
        .alloc_link   (ld_alloc_idx),
        .addr_valid   (st_addr_valid),
        .addr_idx     (st_addr_idx),
        .addr_blk     (blk_t'(st_addr_blk)),
        .ld_res_valid (ld_addr_valid),
        .ld_res_idx   (ld_addr_idx),
        .ld_res_blk   (blk_t'(ld_addr_blk)),
        .retire_req   (st_retire),
        .full         (sq_full),
        .tail         (st_alloc_idx),
        .st_valid     (st_valid),
        .st_res       (st_res),
        .st_blk       (st_blk),
        .free_valid   (st_free_valid),
        .free_idx     (st_free_idx),
        .evt_a_valid  (evt_a_valid),
        .evt_a_idx    (evt_a_idx),
        .evt_a_blk    (evt_a_blk),
        .evt_b_valid  (evt_b_valid),
        .evt_b_idx    (evt_b_idx),
        .evt_b_blk    (evt_b_blk)
    );

    lsq_load_q #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .PI_W(PI_W)) u_lq (
        .clk           (clk),
        .rst           (rst),
        .alloc_fire    (ld_fire),
        .alloc_pidx    (ld_alloc_pcidx),
        .alloc_safe    (pred_safe),
        .st_valid      (st_valid),
        .st_res        (st_res),
        .st_blk        (st_blk),
        .st_free_valid (st_free_valid),
        .st_free_idx   (st_free_idx),
        .addr_valid    (ld_addr_valid),
        .addr_idx      (ld_addr_idx),
        .addr_blk      (blk_t'(ld_addr_blk)),
        .evt_a_valid   (evt_a_valid),
        .evt_a_idx     (evt_a_idx),
        .evt_a_blk     (evt_a_blk),
        .evt_b_valid   (evt_b_valid),
        .evt_b_idx     (evt_b_idx),
        .evt_b_blk     (evt_b_blk),
        .complete_req  (ld_complete),
        .full          (lq_full),
        .tail          (ld_alloc_idx),
        .issue_valid   (ld_issue_valid),
        .issue_idx     (ld_issue_idx),
        .viol_valid    (viol_valid),
        .viol_idx      (viol_idx),
        .trn_valid     (trn_valid),
        .trn_pidx      (trn_pidx)
    );

    AST_FUSED_BOTH: assert property (@(posedge clk) disable iff (rst)
        (fused_req && (lq_full || sq_full)) |-> !(ld_fire || st_fire)); // R1

endmodule

// File: tb/lsq_order_top_bench.sv
`timescale 1ns/1ps
module lsq_order_top_bench;

    localparam int LQD = 4;
    localparam int SQD = 3;
    localparam int PRD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        ld_alloc_valid = 0, st_alloc_valid = 0, alloc_fused = 0;
    logic [2:0]  ld_alloc_pcidx = '0;
    logic        ld_alloc_ready, st_alloc_ready;
    logic [1:0]  ld_alloc_idx, st_alloc_idx;
    logic        ld_addr_valid = 0, st_addr_valid = 0;
    logic [1:0]  ld_addr_idx = '0, st_addr_idx = '0;
    logic [44:0] ld_addr_blk = '0, st_addr_blk = '0;
    logic        ld_complete = 0, st_retire = 0;
    logic        ld_issue_valid, viol_valid;
    logic [1:0]  ld_issue_idx, viol_idx;

    lsq_order_top #(.LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .PRED_ENTRIES(PRD)) u_lsq_order_top (
        .clk(clk), .rst(rst),
        .ld_alloc_valid(ld_alloc_valid), .ld_alloc_pcidx(ld_alloc_pcidx),
        .ld_alloc_ready(ld_alloc_ready), .ld_alloc_idx(ld_alloc_idx),
        .st_alloc_valid(st_alloc_valid), .st_alloc_ready(st_alloc_ready),
        .st_alloc_idx(st_alloc_idx), .alloc_fused(alloc_fused),
        .ld_addr_valid(ld_addr_valid), .ld_addr_idx(ld_addr_idx), .ld_addr_blk(ld_addr_blk),
        .st_addr_valid(st_addr_valid), .st_addr_idx(st_addr_idx), .st_addr_blk(st_addr_blk),
        .ld_complete(ld_complete), .st_retire(st_retire),
        .ld_issue_valid(ld_issue_valid), .ld_issue_idx(ld_issue_idx),
        .viol_valid(viol_valid), .viol_idx(viol_idx)
    );

    int errs = 0, checks = 0;
    int exp_issue[$];
    int exp_viol[$];
    localparam logic [2:0] PC_A = 3'd0, PC_B = 3'd1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // monitor: pop expected grants and violations as they appear
    always @(negedge clk) begin
        if (!rst) begin
            if (ld_issue_valid) begin
                if (exp_issue.size() == 0)
                    chk(0, "R9", "unexpected grant", ld_issue_idx, -1);
                else begin
                    int e;
                    e = exp_issue.pop_front();
                    chk(ld_issue_idx == e, "R9", "grant slot", ld_issue_idx, e);
                end
            end
            if (viol_valid) begin
                if (exp_viol.size() == 0)
                    chk(0, "R6", "unexpected violation", viol_idx, -1);
                else begin
                    int e;
                    e = exp_viol.pop_front();
                    chk(viol_idx == e, "R6", "violation slot", viol_idx, e);
                end
            end
        end
    end

    task automatic ld_alloc(input logic [2:0] pc, input int exp_idx, input string req);
        @(negedge clk);
        chk(ld_alloc_idx == exp_idx, req, "load slot", ld_alloc_idx, exp_idx);
        ld_alloc_valid = 1; ld_alloc_pcidx = pc;
        @(posedge clk); #2; ld_alloc_valid = 0;
    endtask

    task automatic st_alloc(input int exp_idx, input string req);
        @(negedge clk);
        chk(st_alloc_idx == exp_idx, req, "store slot", st_alloc_idx, exp_idx);
        st_alloc_valid = 1;
        @(posedge clk); #2; st_alloc_valid = 0;
    endtask

    task automatic fused_alloc(input logic [2:0] pc);
        @(negedge clk);
        ld_alloc_valid = 1; st_alloc_valid = 1; alloc_fused = 1; ld_alloc_pcidx = pc;
        @(posedge clk); #2;
        ld_alloc_valid = 0; st_alloc_valid = 0; alloc_fused = 0;
    endtask

    task automatic ld_addr(input int idx, input logic [47:0] pa);
        @(negedge clk);
        ld_addr_valid = 1; ld_addr_idx = 2'(idx); ld_addr_blk = pa[47:3];
        @(posedge clk); #2; ld_addr_valid = 0;
    endtask

    task automatic st_addr(input int idx, input logic [47:0] pa);
        @(negedge clk);
        st_addr_valid = 1; st_addr_idx = 2'(idx); st_addr_blk = pa[47:3];
        @(posedge clk); #2; st_addr_valid = 0;
    endtask

    task automatic complete_ld;
        @(negedge clk); ld_complete = 1;
        @(posedge clk); #2; ld_complete = 0;
    endtask

    task automatic retire_st;
        @(negedge clk); st_retire = 1;
        @(posedge clk); #2; st_retire = 0;
    endtask

    task automatic drained(input string req);
        repeat (6) @(negedge clk);
        chk(exp_issue.size() == 0, req, "missing grants", exp_issue.size(), 0);
        chk(exp_viol.size() == 0, req, "missing violations", exp_viol.size(), 0);
    endtask

    initial begin
        #(8 * 200000);
        chk(0, "R9", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(ld_alloc_ready == 1, "R10", "load ready", ld_alloc_ready, 1);
        chk(st_alloc_ready == 1, "R10", "store ready", st_alloc_ready, 1);
        chk(ld_alloc_idx == 0, "R10", "load tail", ld_alloc_idx, 0);
        chk(st_alloc_idx == 0, "R10", "store tail", st_alloc_idx, 0);
        chk(!ld_issue_valid && !viol_valid, "R10", "idle outputs", ld_issue_valid, 0);

        // R3: load with no older stores
        ld_alloc(PC_B, 0, "R2");
        exp_issue.push_back(0);
        ld_addr(0, 48'h1000);
        drained("R3");
        complete_ld();

        // R5 speculative pass, R6 violation
        st_alloc(0, "R2");
        ld_alloc(PC_A, 1, "R2");
        exp_issue.push_back(1);
        ld_addr(1, 48'h2000);
        drained("R5");
        exp_viol.push_back(1);
        st_addr(0, 48'h2004);
        drained("R6");
        retire_st();
        complete_ld();

        // R7 trained wait, then R3 different block releases it
        st_alloc(1, "R2");
        ld_alloc(PC_A, 2, "R2");
        ld_addr(2, 48'h3000);
        repeat (6) @(negedge clk);
        chk(exp_issue.size() == 0, "R7", "trained load held", 0, 0);
        exp_issue.push_back(2);
        st_addr(1, 48'h3008);
        drained("R3");
        retire_st();
        complete_ld();

        // R4 resolved same-block store holds the load until it retires
        st_alloc(2, "R2");
        ld_alloc(PC_B, 3, "R2");
        st_addr(2, 48'h4000);
        ld_addr(3, 48'h4003);
        repeat (6) @(negedge clk);
        chk(exp_issue.size() == 0, "R4", "load held by store", 0, 0);
        exp_issue.push_back(3);
        retire_st();
        drained("R4");
        complete_ld();

        // R2 wraparound of both tails
        @(negedge clk);
        chk(ld_alloc_idx == 0, "R2", "load tail wrapped", ld_alloc_idx, 0);
        chk(st_alloc_idx == 0, "R2", "store tail wrapped", st_alloc_idx, 0);

        // R8 fused pair resolves its store through the load address
        fused_alloc(PC_B);
        @(negedge clk);
        chk(ld_alloc_idx == 1, "R8", "fused load taken", ld_alloc_idx, 1);
        chk(st_alloc_idx == 1, "R8", "fused store taken", st_alloc_idx, 1);
        ld_alloc(PC_A, 1, "R2");
        ld_addr(1, 48'h5000);
        repeat (6) @(negedge clk);
        chk(exp_issue.size() == 0, "R8", "younger load held", 0, 0);
        exp_issue.push_back(0);
        exp_issue.push_back(1);
        ld_addr(0, 48'h6000);
        drained("R8");
        retire_st();
        complete_ld();
        complete_ld();

        // R1 load queue full, store queue unaffected
        ld_alloc(PC_B, 2, "R1");
        ld_alloc(PC_B, 3, "R1");
        ld_alloc(PC_B, 0, "R1");
        ld_alloc(PC_B, 1, "R1");
        @(negedge clk);
        chk(ld_alloc_ready == 0, "R1", "load ready when full", ld_alloc_ready, 0);
        chk(st_alloc_ready == 1, "R1", "store ready independent", st_alloc_ready, 1);
        ld_alloc(PC_B, 2, "R1");
        @(negedge clk);
        chk(ld_alloc_idx == 2, "R1", "tail kept when full", ld_alloc_idx, 2);
        exp_issue.push_back(2); ld_addr(2, 48'h7000);
        exp_issue.push_back(3); ld_addr(3, 48'h7100);
        exp_issue.push_back(0); ld_addr(0, 48'h7200);
        exp_issue.push_back(1); ld_addr(1, 48'h7300);
        drained("R9");
        repeat (4) complete_ld();
        @(negedge clk);
        chk(ld_alloc_ready == 1, "R2", "load ready after frees", ld_alloc_ready, 1);

        // R1 store queue full
        st_alloc(1, "R1");
        st_alloc(2, "R1");
        st_alloc(0, "R1");
        @(negedge clk);
        chk(st_alloc_ready == 0, "R1", "store ready when full", st_alloc_ready, 0);
        chk(ld_alloc_ready == 1, "R1", "load ready independent", ld_alloc_ready, 1);
        st_addr(1, 48'h8000);
        retire_st();
        @(negedge clk);
        chk(st_alloc_ready == 1, "R2", "store ready after retire", st_alloc_ready, 1);
        st_addr(2, 48'h8100);
        st_addr(0, 48'h8200);
        retire_st();
        retire_st();
        drained("R9");

        summary();
        $finish;
    end

endmodule